// File: doc/BRIEF.md
# Far Return Privilege Checker

This block judges whether a protected-mode far return may proceed. Its inputs are the current privilege level, the code and stack selectors already taken off the stack, the decoded attributes of the two descriptors those selectors name, the limits of the global and local descriptor tables, and the state of the four data segment registers. From these it produces one of two results. The first is a single fault, made up of a kind and a 16-bit error code. The second is a decision between a return at the same privilege level and a return to an outer (less privileged) level.

Checks run in a fixed order and only the first failing check is reported. Code segment checks all come before stack segment checks. Within each segment, the general protection checks come before the presence check. When the return goes to an outer level and nothing faults, the block also reports which data segment registers would become reachable at the new, weaker privilege level and must therefore be loaded with a null selector.

The block is one pipeline stage. A request is captured on a valid strobe, and its result is presented on the next cycle with its own valid flag. Reading descriptors from memory and performing the stack pops are done elsewhere.

Top module: `farret_priv_check`

## Requirements
- R1: The fault kind output is encoded as 0 for none, 1 for general protection, 2 for stack fault and 3 for not present. The error code puts the selector's bits 15:2 in place and forces bits 1:0 to zero. If the code selector has bits 15:2 all zero (null), the result is a general protection fault with error code 0.
- R2: Bit 2 of a selector picks the table: 0 for global, 1 for local. A selector whose last descriptor byte, {index,3'b111}, is above that table's limit raises a general protection fault carrying the selector.
- R3: A code descriptor that is not a code segment raises a general protection fault carrying the selector. In 64-bit mode, a code descriptor that has both its L and D bits set raises the same fault. Outside 64-bit mode, L and D together are accepted.
- R4: A code selector RPL (bits 1:0) below the current privilege level raises a general protection fault carrying the selector.
- R5: A conforming code segment faults (general protection, selector) only when its DPL is above the selector RPL. A non-conforming code segment faults whenever its DPL differs from the RPL.
- R6: A code segment that is not present raises a not-present fault carrying the code selector. Any general protection condition on the code segment takes precedence over it.
- R7: When the code checks pass and the RPL equals the current privilege level, the result is a same-level return with no fault and an empty null mask. The stack selector and stack attributes are ignored in this case.
- R8: When the RPL is above the current privilege level, the return is outer-level and the stack segment is checked, in this order. A null stack selector gives a general protection fault with code 0. A stack selector beyond its table limit gives a general protection fault carrying the stack selector. An RPL mismatch with the code RPL, a descriptor that is not a writable data segment, or a DPL mismatch with the code RPL gives a general protection fault carrying the stack selector. A stack segment that is not present gives a stack fault carrying the stack selector. Every code segment fault outranks every stack fault.
- R9: On a fault-free outer-level return, mask bit i is set for data register i only if that register is loaded, holds a data segment or a non-conforming code segment, and has a DPL below the new privilege level (the code RPL).
- R10: The result appears exactly one cycle after the input strobe, and out_valid is high for that cycle only. Whenever a fault is reported, the outer-return flag is low and the mask is empty. Reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the other inputs are sampled on this cycle |
| long_mode | input | 1 | Set when the target runs in 64-bit mode |
| cur_pl | input | 2 | Current privilege level |
| gdt_limit | input | 16 | Global table byte limit |
| ldt_limit | input | 16 | Local table byte limit |
| code_sel | input | 16 | Return code selector |
| code_is_code | input | 1 | Code descriptor is a code segment |
| code_conf | input | 1 | Code segment is conforming |
| code_present | input | 1 | Code segment present |
| code_dpl | input | 2 | Code descriptor DPL |
| code_l | input | 1 | Code descriptor L bit |
| code_d | input | 1 | Code descriptor D bit |
| stk_sel | input | 16 | Return stack selector |
| stk_is_data | input | 1 | Stack descriptor is a data segment |
| stk_writable | input | 1 | Stack data segment writable |
| stk_present | input | 1 | Stack segment present |
| stk_dpl | input | 2 | Stack descriptor DPL |
| dseg_loaded | input | 4 | Data register i holds a non-null selector |
| dseg_is_code | input | 4 | Data register i refers to a code segment |
| dseg_conf | input | 4 | Data register i code segment is conforming |
| dseg_dpl | input | 8 | DPL of data register i in bits 2i+1:2i |
| out_valid | output | 1 | Result valid |
| fault_kind | output | 2 | Fault kind (0 none, 1 GP, 2 stack, 3 not present) |
| fault_code | output | 16 | Error code of the reported fault |
| outer_ret | output | 1 | Fault-free return to an outer level |
| null_mask | output | 4 | Data registers that must be nulled |

## Verification
Each result is registered once, so the bench raises the strobe for one cycle starting at a falling edge and reads every output at the next falling edge. That read happens half a cycle after the rising edge that loaded the result. At the falling edge after that, it confirms that out_valid has dropped again. The priority scenarios set two faults at once and confirm that only the higher one comes out. The ignore case fills the stack inputs with bad values on a same-level return and confirms that the result is still clean.

// File: rtl/farret_pkg.sv
package farret_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_GP   = 2'd1,
    FK_SS   = 2'd2,
    FK_NP   = 2'd3
  } fault_e;
endpackage

// File: rtl/farret_code_check.sv
module farret_code_check
  import farret_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int PL_W  = 2
) (
  input  logic             long_mode,
  input  logic [PL_W-1:0]  cur_pl,
  input  logic [SEL_W-1:0] gdt_limit,
  input  logic [SEL_W-1:0] ldt_limit,
  input  logic [SEL_W-1:0] sel,
  input  logic             is_code,
  input  logic             conf,
  input  logic             present,
  input  logic [PL_W-1:0]  dpl,
  input  logic             l_bit,
  input  logic             d_bit,
  output fault_e           kind,
  output logic [SEL_W-1:0] err,
  output logic             outer
);
  logic [PL_W-1:0]  rpl;
  logic [SEL_W-1:0] last_byte;
  logic [SEL_W-1:0] lim;
  logic [SEL_W-1:0] sel_err;
  logic             is_null;

  assign rpl       = sel[PL_W-1:0];
  assign is_null   = (sel[SEL_W-1:2] == '0);
  assign last_byte = {sel[SEL_W-1:3], 3'b111};
  assign lim       = sel[2] ? ldt_limit : gdt_limit;
  assign sel_err   = {sel[SEL_W-1:2], 2'b00};
  assign outer     = (rpl > cur_pl);

  // Checks in fixed priority: first match wins.
  always_comb begin
    kind = FK_NONE;
    err  = '0;
    if (is_null) begin
      kind = FK_GP;
    end else if (last_byte > lim) begin
      kind = FK_GP; err = sel_err;
    end else if (!is_code) begin
      kind = FK_GP; err = sel_err;
    end else if (long_mode && l_bit && d_bit) begin
      kind = FK_GP; err = sel_err;
    end else if (rpl < cur_pl) begin
      kind = FK_GP; err = sel_err;
    end else if (conf && (dpl > rpl)) begin
      kind = FK_GP; err = sel_err;
    end else if (!conf && (dpl != rpl)) begin
      kind = FK_GP; err = sel_err;
    end else if (!present) begin
      kind = FK_NP; err = sel_err;
    end
  end
endmodule

// File: rtl/farret_stack_check.sv
module farret_stack_check
  import farret_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int PL_W  = 2
) (
  input  logic [SEL_W-1:0] gdt_limit,
  input  logic [SEL_W-1:0] ldt_limit,
  input  logic [PL_W-1:0]  code_rpl,
  input  logic [SEL_W-1:0] sel,
  input  logic             is_data,
  input  logic             writable,
  input  logic             present,
  input  logic [PL_W-1:0]  dpl,
  output fault_e           kind,
  output logic [SEL_W-1:0] err
);
  logic [SEL_W-1:0] last_byte;
  logic [SEL_W-1:0] lim;
  logic [SEL_W-1:0] sel_err;
  logic             attr_bad;

  assign last_byte = {sel[SEL_W-1:3], 3'b111};
  assign lim       = sel[2] ? ldt_limit : gdt_limit;
  assign sel_err   = {sel[SEL_W-1:2], 2'b00};
  assign attr_bad  = (sel[PL_W-1:0] != code_rpl) || !is_data || !writable ||
                     (dpl != code_rpl);

  always_comb begin
    kind = FK_NONE;
    err  = '0;
    if (sel[SEL_W-1:2] == '0) begin
      kind = FK_GP;
    end else if (last_byte > lim) begin
      kind = FK_GP; err = sel_err;
    end else if (attr_bad) begin
      kind = FK_GP; err = sel_err;
    end else if (!present) begin
      kind = FK_SS; err = sel_err;
    end
  end
endmodule

// File: rtl/farret_dseg_scrub.sv
module farret_dseg_scrub #(
  parameter int PL_W     = 2,
  parameter int NUM_DSEG = 4
) (
  input  logic [PL_W-1:0]          new_pl,
  input  logic [NUM_DSEG-1:0]      loaded,
  input  logic [NUM_DSEG-1:0]      is_code,
  input  logic [NUM_DSEG-1:0]      conf,
  input  logic [NUM_DSEG*PL_W-1:0] dpl,
  output logic [NUM_DSEG-1:0]      mask
);
  for (genvar i = 0; i < NUM_DSEG; i++) begin : g_seg
    logic [PL_W-1:0] seg_dpl;
    assign seg_dpl = dpl[i*PL_W +: PL_W];
    // Conforming code stays usable at any level; everything else is tested.
    assign mask[i] = loaded[i] && !(is_code[i] && conf[i]) && (seg_dpl < new_pl);
  end
endmodule

// File: rtl/farret_priv_check.sv
module farret_priv_check
  import farret_pkg::*;
#(
  parameter int SEL_W    = 16,
  parameter int PL_W     = 2,
  parameter int NUM_DSEG = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     long_mode,
  input  logic [PL_W-1:0]          cur_pl,
  input  logic [SEL_W-1:0]         gdt_limit,
  input  logic [SEL_W-1:0]         ldt_limit,
  input  logic [SEL_W-1:0]         code_sel,
  input  logic                     code_is_code,
  input  logic                     code_conf,
  input  logic                     code_present,
  input  logic [PL_W-1:0]          code_dpl,
  input  logic                     code_l,
  input  logic                     code_d,
  input  logic [SEL_W-1:0]         stk_sel,
  input  logic                     stk_is_data,
  input  logic                     stk_writable,
  input  logic                     stk_present,
  input  logic [PL_W-1:0]          stk_dpl,
  input  logic [NUM_DSEG-1:0]      dseg_loaded,
  input  logic [NUM_DSEG-1:0]      dseg_is_code,
  input  logic [NUM_DSEG-1:0]      dseg_conf,
  input  logic [NUM_DSEG*PL_W-1:0] dseg_dpl,
  output logic                     out_valid,
  output logic [1:0]               fault_kind,
  output logic [SEL_W-1:0]         fault_code,
  output logic                     outer_ret,
  output logic [NUM_DSEG-1:0]      null_mask
);
  fault_e            c_kind, s_kind, n_kind;
  logic [SEL_W-1:0]  c_err, s_err, n_err;
  logic              c_outer, n_outer;
  logic [NUM_DSEG-1:0] raw_mask, n_mask;

  farret_code_check #(.SEL_W(SEL_W), .PL_W(PL_W)) u_code (
    .long_mode (long_mode),
    .cur_pl    (cur_pl),
    .gdt_limit (gdt_limit),
    .ldt_limit (ldt_limit),
    .sel       (code_sel),
    .is_code   (code_is_code),
    .conf      (code_conf),
    .present   (code_present),
    .dpl       (code_dpl),
    .l_bit     (code_l),
    .d_bit     (code_d),
    .kind      (c_kind),
    .err       (c_err),
    .outer     (c_outer)
  );

  farret_stack_check #(.SEL_W(SEL_W), .PL_W(PL_W)) u_stack (
    .gdt_limit (gdt_limit),
    .ldt_limit (ldt_limit),
    .code_rpl  (code_sel[PL_W-1:0]),
    .sel       (stk_sel),
    .is_data   (stk_is_data),
    .writable  (stk_writable),
    .present   (stk_present),
    .dpl       (stk_dpl),
    .kind      (s_kind),
    .err       (s_err)
  );

  farret_dseg_scrub #(.PL_W(PL_W), .NUM_DSEG(NUM_DSEG)) u_scrub (
    .new_pl  (code_sel[PL_W-1:0]),
    .loaded  (dseg_loaded),
    .is_code (dseg_is_code),
    .conf    (dseg_conf),
    .dpl     (dseg_dpl),
    .mask    (raw_mask)
  );

  // Merge: code faults first, stack only on the outer path.
  always_comb begin
    n_kind  = c_kind;
    n_err   = c_err;
    n_outer = 1'b0;
    n_mask  = '0;
    if (c_kind == FK_NONE && c_outer) begin
      n_kind = s_kind;
      n_err  = s_err;
      if (s_kind == FK_NONE) begin
        n_outer = 1'b1;
        n_mask  = raw_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      fault_kind <= FK_NONE;
      fault_code <= '0;
      outer_ret  <= 1'b0;
      null_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fault_kind <= n_kind;
        fault_code <= n_err;
        outer_ret  <= n_outer;
        null_mask  <= n_mask;
      end
    end
  end
endmodule

// File: rtl/farret_priv_check_sva.sv
module farret_priv_check_sva #(
  parameter int SEL_W    = 16,
  parameter int PL_W     = 2,
  parameter int NUM_DSEG = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [PL_W-1:0]     cur_pl,
  input logic [SEL_W-1:0]    code_sel,
  input logic                out_valid,
  input logic [1:0]          fault_kind,
  input logic [SEL_W-1:0]    fault_code,
  input logic                outer_ret,
  input logic [NUM_DSEG-1:0] null_mask
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == $past(in_valid)));

  a_r10_fault_clears: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fault_kind != 2'd0) |-> (!outer_ret && null_mask == '0));

  a_r1_null_code: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid && $past(code_sel[SEL_W-1:2]) == '0) |->
      (fault_kind == 2'd1 && fault_code == '0));

  a_r4_no_inward: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid && fault_kind == 2'd0) |->
      ($past(code_sel[PL_W-1:0]) >= $past(cur_pl)));

  a_r7_level_pick: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid && fault_kind == 2'd0) |->
      (outer_ret == ($past(code_sel[PL_W-1:0]) > $past(cur_pl))));

  a_r9_mask_outer_only: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !outer_ret) |-> (null_mask == '0));

  a_r1_err_low_bits: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fault_code[1:0] == 2'b00));
endmodule

bind farret_priv_check farret_priv_check_sva #(
  .SEL_W(SEL_W), .PL_W(PL_W), .NUM_DSEG(NUM_DSEG)
) u_sva (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .cur_pl     (cur_pl),
  .code_sel   (code_sel),
  .out_valid  (out_valid),
  .fault_kind (fault_kind),
  .fault_code (fault_code),
  .outer_ret  (outer_ret),
  .null_mask  (null_mask)
);

// File: tb/farret_priv_check_tb.sv
module farret_priv_check_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        long_mode;
  logic [1:0]  cur_pl;
  logic [15:0] gdt_limit, ldt_limit, code_sel, stk_sel;
  logic        code_is_code, code_conf, code_present, code_l, code_d;
  logic [1:0]  code_dpl, stk_dpl;
  logic        stk_is_data, stk_writable, stk_present;
  logic [3:0]  dseg_loaded, dseg_is_code, dseg_conf;
  logic [7:0]  dseg_dpl;
  logic        out_valid, outer_ret;
  logic [1:0]  fault_kind;
  logic [15:0] fault_code;
  logic [3:0]  null_mask;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  farret_priv_check dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .long_mode(long_mode),
    .cur_pl(cur_pl), .gdt_limit(gdt_limit), .ldt_limit(ldt_limit),
    .code_sel(code_sel), .code_is_code(code_is_code), .code_conf(code_conf),
    .code_present(code_present), .code_dpl(code_dpl), .code_l(code_l),
    .code_d(code_d), .stk_sel(stk_sel), .stk_is_data(stk_is_data),
    .stk_writable(stk_writable), .stk_present(stk_present), .stk_dpl(stk_dpl),
    .dseg_loaded(dseg_loaded), .dseg_is_code(dseg_is_code),
    .dseg_conf(dseg_conf), .dseg_dpl(dseg_dpl), .out_valid(out_valid),
    .fault_kind(fault_kind), .fault_code(fault_code), .outer_ret(outer_ret),
    .null_mask(null_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Legal same-level return at level 3, clean stack for an outer return.
  task automatic base_same();
    long_mode = 1'b0; cur_pl = 2'd3;
    gdt_limit = 16'h00FF; ldt_limit = 16'h003F;
    code_sel = 16'h001B; code_is_code = 1'b1; code_conf = 1'b0;
    code_present = 1'b1; code_dpl = 2'd3; code_l = 1'b0; code_d = 1'b0;
    stk_sel = 16'h0023; stk_is_data = 1'b1; stk_writable = 1'b1;
    stk_present = 1'b1; stk_dpl = 2'd3;
    dseg_loaded = 4'hF; dseg_is_code = 4'h0; dseg_conf = 4'h0; dseg_dpl = 8'hFF;
  endtask

  task automatic base_outer();
    base_same();
    cur_pl = 2'd0;
  endtask

  // Strobe for one cycle, read at the next falling edge, then confirm drop.
  task automatic fire(input string req, input logic [1:0] ek, input logic [15:0] ec,
                      input logic eo, input logic [3:0] em);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, out_valid, 1);
    chk({req, " kind"}, fault_kind, ek);
    chk({req, " code"}, fault_code, ec);
    chk({req, " outer"}, outer_ret, eo);
    chk({req, " mask"}, null_mask, em);
    @(negedge clk);
    chk({req, " valid drop R10"}, out_valid, 0);
  endtask

  task automatic t_reset();
    chk("R10 reset valid", out_valid, 0);
    chk("R10 reset kind", fault_kind, 0);
  endtask

  task automatic t_null_code();
    base_outer(); code_sel = 16'h0003; code_present = 1'b0;
    fire("R1 null code", 2'd1, 16'h0000, 0, 4'h0);
  endtask

  task automatic t_limit();
    base_same(); code_sel = 16'h0203;
    fire("R2 gdt limit", 2'd1, 16'h0200, 0, 4'h0);
    base_same(); code_sel = 16'h003F; // local, last byte 0x3F == limit
    fire("R2 ldt edge ok", 2'd0, 16'h0000, 0, 4'h0);
    base_same(); code_sel = 16'h0047; // local, last byte 0x47 > 0x3F
    fire("R2 ldt over", 2'd1, 16'h0044, 0, 4'h0);
  endtask

  task automatic t_type();
    base_same(); code_is_code = 1'b0; code_present = 1'b0;
    fire("R3 not code beats NP", 2'd1, 16'h0018, 0, 4'h0);
    base_same(); long_mode = 1'b1; code_l = 1'b1; code_d = 1'b1;
    fire("R3 L and D in 64-bit", 2'd1, 16'h0018, 0, 4'h0);
    base_same(); long_mode = 1'b0; code_l = 1'b1; code_d = 1'b1;
    fire("R3 L and D legacy ok", 2'd0, 16'h0000, 0, 4'h0);
  endtask

  task automatic t_rpl();
    base_same(); code_sel = 16'h0019; code_dpl = 2'd1; cur_pl = 2'd2;
    fire("R4 rpl below cpl", 2'd1, 16'h0018, 0, 4'h0);
  endtask

  task automatic t_conf();
    base_same(); code_conf = 1'b1; code_dpl = 2'd1;
    fire("R5 conforming lower dpl ok", 2'd0, 16'h0000, 0, 4'h0);
    base_same(); code_sel = 16'h0019; cur_pl = 2'd1; code_conf = 1'b1; code_dpl = 2'd2;
    fire("R5 conforming higher dpl", 2'd1, 16'h0018, 0, 4'h0);
    base_same(); code_conf = 1'b0; code_dpl = 2'd2;
    fire("R5 nonconforming mismatch", 2'd1, 16'h0018, 0, 4'h0);
  endtask

  task automatic t_np();
    base_outer(); code_present = 1'b0; stk_sel = 16'h0000;
    fire("R6 code NP beats stack", 2'd3, 16'h0018, 0, 4'h0);
  endtask

  task automatic t_same_ignores_stack();
    base_same(); stk_sel = 16'h0000; stk_is_data = 1'b0; stk_present = 1'b0;
    dseg_dpl = 8'h00;
    fire("R7 same level ignores stack", 2'd0, 16'h0000, 0, 4'h0);
  endtask

  task automatic t_stack();
    base_outer(); stk_sel = 16'h0003;
    fire("R8 null stack", 2'd1, 16'h0000, 0, 4'h0);
    base_outer(); stk_sel = 16'h0403;
    fire("R8 stack limit", 2'd1, 16'h0400, 0, 4'h0);
    base_outer(); stk_sel = 16'h0022; stk_present = 1'b0;
    fire("R8 stack rpl beats SS", 2'd1, 16'h0020, 0, 4'h0);
    base_outer(); stk_writable = 1'b0;
    fire("R8 stack read-only", 2'd1, 16'h0020, 0, 4'h0);
    base_outer(); stk_dpl = 2'd2;
    fire("R8 stack dpl", 2'd1, 16'h0020, 0, 4'h0);
    base_outer(); stk_present = 1'b0;
    fire("R8 stack not present", 2'd2, 16'h0020, 0, 4'h0);
  endtask

  task automatic t_scrub();
    base_outer();
    // seg0 data dpl0 -> null; seg1 conforming code dpl0 -> keep;
    // seg2 unloaded data dpl0 -> keep; seg3 nonconforming code dpl1 -> null
    dseg_loaded = 4'b1011; dseg_is_code = 4'b1010; dseg_conf = 4'b0010;
    dseg_dpl = {2'd1, 2'd0, 2'd0, 2'd0};
    fire("R9 scrub mask", 2'd0, 16'h0000, 1, 4'b1001);
    base_outer(); dseg_dpl = 8'hFF;
    fire("R9 all at new level kept", 2'd0, 16'h0000, 1, 4'b0000);
    base_outer(); dseg_dpl = 8'h00; stk_present = 1'b0;
    fire("R10 fault clears mask", 2'd2, 16'h0020, 0, 4'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    base_same();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_null_code();
    t_limit();
    t_type();
    t_rpl();
    t_conf();
    t_np();
    t_same_ignores_stack();
    t_stack();
    t_scrub();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule